// File: doc/BRIEF.md
# Multiplexed Bus Byte-Lane Target

This block sits on the device side of a 16-bit bus whose address and data share one set of AD lines. The bus phase clock E splits each transfer. While E is low the lines hold the address. While E is high they hold data. The block captures the address when E rises. It works out which byte lanes the transfer touches from address bit 0 and an active-low low-byte strobe. It then either writes the selected bytes of a word in its internal storage or drives the selected lanes back to the master.

The whole block runs from one system clock that oversamples E, and every edge of E is detected synchronously. The data lines are modelled as an input bus, an output bus and one output enable per byte lane, and the pad ring builds the tri-state drivers from these. A parameterised base address and size set the window the device answers to. A transfer outside that window leaves the bus undriven and changes no stored byte.

Top module: `mux_bus_target`

## Requirements
- R1: While reset is asserted both lane output enables are low.
- R2: Address, direction and strobe are sampled from the bus on the first system-clock edge that sees E high. Later changes of `ad_in` during the same high phase do not change which word or lanes the transfer uses.
- R3: Address bit 0 = 0 with `lstrb_n` = 0 is a word access. It covers the even byte on `ad[15:8]` and the odd byte on `ad[7:0]`.
- R4: Address bit 0 = 0 with `lstrb_n` = 1 touches only the even byte, which travels on `ad[15:8]`.
- R5: Address bit 0 = 1 with `lstrb_n` = 0 touches only the odd byte, which travels on `ad[7:0]`.
- R6: Address bit 0 = 1 with `lstrb_n` = 1 is no access. No lane is driven and no byte is written.
- R7: For a read (`bus_rw` = 1) inside the window, each selected lane's enable is high while E is high, one clock behind E. The lane carries the stored byte of word (address − base)/2.
- R8: A write (`bus_rw` = 0) commits the selected bytes on the clock edge that first sees E low. It uses the last data sampled while E was high and never asserts an output enable.
- R9: An address below the base, or at or above base + size, drives no lane and writes no byte.
- R10: Both enables are low one clock after a clock edge that samples E low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples E |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_e | input | 1 | Bus phase clock: low = address phase, high = data phase |
| bus_rw | input | 1 | Direction: 1 = master reads, 0 = master writes |
| lstrb_n | input | 1 | Active-low strobe for the odd (low) byte lane |
| ad_in | input | 16 | Shared address/data lines as seen by the device |
| ad_out | output | 16 | Read data for the lanes, valid where enabled |
| ad_oe_hi | output | 1 | Drive enable for ad[15:8] (even byte) |
| ad_oe_lo | output | 1 | Drive enable for ad[7:0] (odd byte) |

## Verification
The bench goes after the fourth strobe combination. A decoder that lets address bit 0 = 1 with the strobe high fall through to a lane would corrupt the odd byte or drive the bus. During the data phase of reads, the bench puts a different in-window address on the lines. A design that re-samples the address after E rises would then return the wrong word. Writes just past the top of the window alias onto word 0 if the range check is dropped, and writes one word below the base do the same at the top word. Byte writes followed by word reads show when the wrong lane was written or when the partner byte was disturbed.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_EVEN = 2'd1,
    ACC_ODD  = 2'd2,
    ACC_WORD = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic hi;  // even byte, ad[15:8]
    logic lo;  // odd byte, ad[7:0]
  } lanes_t;

  function automatic acc_kind_e classify(input logic a0, input logic strb_n);
    acc_kind_e k;
    unique case ({a0, strb_n})
      2'b00:   k = ACC_WORD;
      2'b01:   k = ACC_EVEN;
      2'b10:   k = ACC_ODD;
      default: k = ACC_NONE;
    endcase
    return k;
  endfunction

  function automatic lanes_t kind_lanes(input acc_kind_e k);
    lanes_t l;
    l.hi = (k == ACC_WORD) || (k == ACC_EVEN);
    l.lo = (k == ACC_WORD) || (k == ACC_ODD);
    return l;
  endfunction

endpackage

// File: rtl/mbt_phase_latch.sv
module mbt_phase_latch #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_e,
  input  logic          bus_rw,
  input  logic          lstrb_n,
  input  logic [DW-1:0] ad_in,
  output logic          e_q,
  output logic          e_rise,
  output logic          e_fall,
  output logic [AW-1:0] lat_addr,
  output logic          lat_rw,
  output logic          lat_lstrb_n,
  output logic [DW-1:0] data_q
);

  logic [AW-1:0] addr_nxt;
  logic          rw_nxt;
  logic          strb_nxt;
  logic [DW-1:0] data_nxt;

  assign e_rise = bus_e & ~e_q;
  assign e_fall = ~bus_e & e_q;

  always_comb begin
    addr_nxt = lat_addr;
    rw_nxt   = lat_rw;
    strb_nxt = lat_lstrb_n;
    data_nxt = data_q;
    if (e_rise) begin
      addr_nxt = ad_in[AW-1:0];
      rw_nxt   = bus_rw;
      strb_nxt = lstrb_n;
    end
    if (bus_e) begin
      data_nxt = ad_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q         <= 1'b0;
      lat_addr    <= '0;
      lat_rw      <= 1'b0;
      lat_lstrb_n <= 1'b1;
      data_q      <= '0;
    end else begin
      e_q         <= bus_e;
      lat_addr    <= addr_nxt;
      lat_rw      <= rw_nxt;
      lat_lstrb_n <= strb_nxt;
      data_q      <= data_nxt;
    end
  end

endmodule

// File: rtl/mbt_lane_decode.sv
module mbt_lane_decode
  import mbt_pkg::*;
(
  input  logic a0,
  input  logic strb_n,
  output logic lane_hi,
  output logic lane_lo
);

  acc_kind_e kind;
  lanes_t    lanes;

  always_comb begin
    kind    = classify(a0, strb_n);
    lanes   = kind_lanes(kind);
    lane_hi = lanes.hi;
    lane_lo = lanes.lo;
  end

endmodule

// File: rtl/mbt_window.sv
module mbt_window #(
  parameter int AW         = 16,
  parameter int BASE_ADDR  = 16'h0400,
  parameter int SIZE_BYTES = 64,
  parameter int IDX_W      = 5
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [IDX_W-1:0] word_idx
);

  localparam logic [AW-1:0] BASE_V = AW'(BASE_ADDR);
  localparam logic [AW:0]   SIZE_V = (AW+1)'(SIZE_BYTES);

  logic [AW-1:0] offset;
  logic [AW:0]   offset_x;

  always_comb begin
    offset   = addr - BASE_V;
    offset_x = {1'b0, offset};
    hit      = (addr >= BASE_V) && (offset_x < SIZE_V);
    word_idx = offset[IDX_W:1];
  end

endmodule

// File: rtl/mbt_word_array.sv
module mbt_word_array #(
  parameter int WORDS = 32,
  parameter int IDX_W = 5,
  parameter int LANES = 2,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [LANES*BW-1:0] wdata,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [LANES*BW-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BW-1:0] mem [WORDS];
    logic [BW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) begin
        mem[wr_idx] <= wdata[g*BW +: BW];
      end
    end

    always_ff @(posedge clk) begin
      rd_q <= mem[rd_idx];
    end

    assign rdata[g*BW +: BW] = rd_q;
  end

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target #(
  parameter int BASE_ADDR  = 16'h0400,
  parameter int SIZE_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_e,
  input  logic        bus_rw,
  input  logic        lstrb_n,
  input  logic [15:0] ad_in,
  output logic [15:0] ad_out,
  output logic        ad_oe_hi,
  output logic        ad_oe_lo
);

  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int BW    = 8;
  localparam int LANES = DW / BW;
  localparam int WORDS = SIZE_BYTES / LANES;
  localparam int IDX_W = $clog2(WORDS);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic          e_q;
  logic          e_rise;
  logic          e_fall;
  logic [AW-1:0] lat_addr;
  logic          lat_rw;
  logic          lat_lstrb_n;
  logic [DW-1:0] data_q;

  mbt_phase_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_e       (bus_e),
    .bus_rw      (bus_rw),
    .lstrb_n     (lstrb_n),
    .ad_in       (ad_in),
    .e_q         (e_q),
    .e_rise      (e_rise),
    .e_fall      (e_fall),
    .lat_addr    (lat_addr),
    .lat_rw      (lat_rw),
    .lat_lstrb_n (lat_lstrb_n),
    .data_q      (data_q)
  );

  logic lane_hi;
  logic lane_lo;

  mbt_lane_decode u_lanes (
    .a0      (lat_addr[0]),
    .strb_n  (lat_lstrb_n),
    .lane_hi (lane_hi),
    .lane_lo (lane_lo)
  );

  logic             hit;
  logic [IDX_W-1:0] word_idx;

  mbt_window #(
    .AW(AW), .BASE_ADDR(BASE_ADDR), .SIZE_BYTES(SIZE_BYTES), .IDX_W(IDX_W)
  ) u_win (
    .addr     (lat_addr),
    .hit      (hit),
    .word_idx (word_idx)
  );

  // write strobes: commit on the edge that first sees E low
  logic             we_hi;
  logic             we_lo;
  logic [LANES-1:0] we_vec;

  always_comb begin
    we_hi  = e_fall & ~lat_rw & hit & lane_hi;
    we_lo  = e_fall & ~lat_rw & hit & lane_lo;
    we_vec = {we_hi, we_lo};
  end

  logic [DW-1:0] rd_word;

  mbt_word_array #(
    .WORDS(WORDS), .IDX_W(IDX_W), .LANES(LANES), .BW(BW)
  ) u_array (
    .clk    (clk),
    .we     (we_vec),
    .wr_idx (word_idx),
    .wdata  (data_q),
    .rd_idx (word_idx),
    .rdata  (rd_word)
  );

  // read drive enables
  logic oe_hi_q;
  logic oe_lo_q;
  logic oe_hi_nxt;
  logic oe_lo_nxt;
  logic rd_phase;

  always_comb begin
    rd_phase  = bus_e & e_q & lat_rw & hit;
    oe_hi_nxt = rd_phase & lane_hi;
    oe_lo_nxt = rd_phase & lane_lo;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oe_hi_q <= 1'b0;
      oe_lo_q <= 1'b0;
    end else begin
      oe_hi_q <= oe_hi_nxt;
      oe_lo_q <= oe_lo_nxt;
    end
  end

  assign ad_out   = rd_word;
  assign ad_oe_hi = oe_hi_q;
  assign ad_oe_lo = oe_lo_q;

endmodule

// File: rtl/mbt_chk.sv
module mbt_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_e,
  input logic lat_a0,
  input logic lat_lstrb_n,
  input logic lat_rw,
  input logic lat_hit,
  input logic e_fall,
  input logic we_hi,
  input logic we_lo,
  input logic oe_hi,
  input logic oe_lo
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!oe_hi && !oe_lo));

  p_even_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_hi || we_hi) |-> !lat_a0);

  p_odd_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_lo || we_lo) |-> !lat_lstrb_n);

  p_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_a0 && lat_lstrb_n) |-> !(oe_hi || oe_lo || we_hi || we_lo));

  p_drive_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_hi || oe_lo) |-> $past(bus_e));

  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rw |-> (!oe_hi && !oe_lo));

  p_commit_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi || we_lo) |-> e_fall);

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_hit |-> !(oe_hi || oe_lo || we_hi || we_lo));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_e |=> (!oe_hi && !oe_lo));

endmodule

bind mux_bus_target mbt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_e       (bus_e),
  .lat_a0      (lat_addr[0]),
  .lat_lstrb_n (lat_lstrb_n),
  .lat_rw      (lat_rw),
  .lat_hit     (hit),
  .e_fall      (e_fall),
  .we_hi       (we_hi),
  .we_lo       (we_lo),
  .oe_hi       (ad_oe_hi),
  .oe_lo       (ad_oe_lo)
);

// File: tb/sim_mux_bus_target.sv
module sim_mux_bus_target;

  localparam int BASE  = 16'h0400;
  localparam int SIZE  = 64;
  localparam int WORDS = SIZE / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_e;
  logic        bus_rw;
  logic        lstrb_n;
  logic [15:0] ad_in;
  logic [15:0] ad_out;
  logic        ad_oe_hi;
  logic        ad_oe_lo;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_hi [WORDS];
  logic [7:0] m_lo [WORDS];

  always #2 clk = ~clk;

  mux_bus_target #(.BASE_ADDR(BASE), .SIZE_BYTES(SIZE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rw(bus_rw),
    .lstrb_n(lstrb_n), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo)
  );

  function automatic logic in_win(input logic [15:0] a);
    return (a >= 16'(BASE)) && (a < 16'(BASE + SIZE));
  endfunction

  function automatic logic [1:0] exp_lanes(input logic a0, input logic sn);
    // {hi, lo}: R3 word, R4 even, R5 odd, R6 none
    case ({a0, sn})
      2'b00:   return 2'b11;
      2'b01:   return 2'b10;
      2'b10:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int widx(input logic [15:0] a);
    return int'((a - 16'(BASE)) >> 1);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus transfer; on return got_* hold the lane enables and data seen in the data phase
  task automatic xfer(input logic [15:0] addr, input logic rd, input logic sn,
                      input logic [15:0] wdata, input logic [15:0] junk,
                      output logic [1:0] got_oe, output logic [15:0] got_d);
    @(negedge clk);
    bus_e = 1'b0; ad_in = addr; bus_rw = rd; lstrb_n = sn;
    @(negedge clk);
    @(negedge clk);
    bus_e = 1'b1;
    @(negedge clk);
    ad_in = rd ? junk : wdata;
    @(negedge clk);
    got_oe = {ad_oe_hi, ad_oe_lo};
    got_d  = ad_out;
    @(negedge clk);
    bus_e = 1'b0;
    @(negedge clk);
    check({ad_oe_hi, ad_oe_lo} == 2'b00, "R10 release",
          16'({ad_oe_hi, ad_oe_lo}), 16'h0);
  endtask

  task automatic do_write(input logic [15:0] addr, input logic sn, input logic [15:0] d);
    logic [1:0]  oe;
    logic [15:0] q;
    logic [1:0]  ln;
    xfer(addr, 1'b0, sn, d, 16'h0, oe, q);
    check(oe == 2'b00, "R8 write drives nothing", 16'(oe), 16'h0);
    ln = exp_lanes(addr[0], sn);
    if (in_win(addr)) begin
      if (ln[1]) m_hi[widx(addr)] = d[15:8];
      if (ln[0]) m_lo[widx(addr)] = d[7:0];
    end
  endtask

  task automatic do_read(input logic [15:0] addr, input logic sn, input logic [15:0] junk,
                         input string tag);
    logic [1:0]  oe;
    logic [15:0] q;
    logic [1:0]  ln;
    xfer(addr, 1'b1, sn, 16'h0, junk, oe, q);
    ln = in_win(addr) ? exp_lanes(addr[0], sn) : 2'b00;
    check(oe == ln, {tag, " lanes"}, 16'(oe), 16'(ln));
    if (ln[1]) check(q[15:8] == m_hi[widx(addr)], {tag, " even byte"},
                     16'(q[15:8]), 16'(m_hi[widx(addr)]));
    if (ln[0]) check(q[7:0] == m_lo[widx(addr)], {tag, " odd byte"},
                     16'(q[7:0]), 16'(m_lo[widx(addr)]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    rst_n = 1'b1; bus_e = 1'b0; bus_rw = 1'b1; lstrb_n = 1'b1; ad_in = 16'h0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({ad_oe_hi, ad_oe_lo} == 2'b00, "R1 reset enables",
          16'({ad_oe_hi, ad_oe_lo}), 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // fill every word with a word write (R3)
    for (int i = 0; i < WORDS; i++) begin
      do_write(16'(BASE + 2*i), 1'b0, 16'(16'hA500 + i*16'h0103));
    end
    for (int i = 0; i < WORDS; i++) begin
      do_read(16'(BASE + 2*i), 1'b0, 16'hFFFF, "R3 word readback");
    end

    // R4 even byte only, odd byte kept
    do_write(16'(BASE + 6), 1'b1, 16'h3C77);
    do_read(16'(BASE + 6), 1'b0, 16'h0000, "R4 even write");
    do_read(16'(BASE + 6), 1'b1, 16'h0000, "R4 even read");

    // R5 odd byte only, even byte kept
    do_write(16'(BASE + 9), 1'b0, 16'h88C3);
    do_read(16'(BASE + 8), 1'b0, 16'h0000, "R5 odd write");
    do_read(16'(BASE + 9), 1'b0, 16'h0000, "R5 odd read");

    // R6 no-access combination: nothing written, nothing driven
    do_write(16'(BASE + 11), 1'b1, 16'h1234);
    do_read(16'(BASE + 10), 1'b0, 16'h0000, "R6 no-access write");
    do_read(16'(BASE + 11), 1'b1, 16'h0000, "R6 no-access read");

    // R2 another in-window address on the lines during the data phase
    do_read(16'(BASE + 4), 1'b0, 16'(BASE + 20), "R2 address held");
    do_read(16'(BASE + 21), 1'b0, 16'(BASE + 2), "R2 address held odd");

    // R9 just outside the window on both sides
    do_write(16'(BASE + SIZE), 1'b0, 16'hDEAD);
    do_write(16'(BASE - 2), 1'b0, 16'hBEEF);
    do_read(16'(BASE), 1'b0, 16'h0000, "R9 top alias");
    do_read(16'(BASE + SIZE - 2), 1'b0, 16'h0000, "R9 bottom alias");
    do_read(16'(BASE + SIZE), 1'b0, 16'h0000, "R9 miss read");
    do_read(16'(BASE - 1), 1'b0, 16'h0000, "R9 miss read below");

    // R7 constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic        sn;
      a  = 16'(BASE - 16 + int'($urandom % (SIZE + 32)));
      sn = 1'($urandom % 2);
      if ($urandom % 2) do_read(a, sn, 16'($urandom), "R7 random read");
      else              do_write(a, sn, 16'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule